// File: doc/BRIEF.md
# Two-Wire Register Slave with Block and Byte Access

This block is a serial slave on a two-wire bus (clock and open-drain data) that gives a host read and write access to a small file of 8-bit control registers. The bus lines arrive as plain inputs sampled by the local clock. Each line passes through a two-flop synchronizer and a glitch filter. Start and stop conditions, and the data bit sampling, are derived from the filtered levels. The slave pulls the data line low by raising a single drive-enable output. It does this for acknowledge bits and for read data zeros.

Two access styles share one device address. A command byte of zero selects block access. A block write then carries a byte count followed by exactly that many data bytes, stored from register 0 upward. A block read, after a repeated start, returns the register count first and then registers from 0 upward until the master declines a byte. Any non-zero command selects byte access to the register whose index is one less than the command. The first four registers are reserved, and the last two hold fixed identity values. Writes to any of these six are acknowledged and dropped. Register 4 holds a software frequency selection. Its five select bits are split across the byte, so the block gathers them into one output field.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69, which is byte 0xD2 for a write and 0xD3 for a read. On any other address it returns NACK and leaves the data line released for the rest of the transfer.
- R2: In a byte write (address 0xD2, command c with c ≥ 1, one data byte), the slave acknowledges all three bytes and stores the data in register c−1. If a second data byte follows, it is NACKed and not stored.
- R3: In a byte read (address 0xD2, command c ≥ 1, repeated start, address 0xD3), the slave returns register c−1, most significant bit first.
- R4: In a block write (command 0x00, then a count N, then data), the slave acknowledges every byte up to and including the N-th data byte. Data byte i goes to register i. A data byte after the N-th is NACKed and not stored.
- R5: In a block read (command 0x00, repeated start, address 0xD3), the first byte returned is the register count, 20. Registers 0, 1, 2 and onward follow for as long as the master acknowledges. After a NACK the slave drives nothing more.
- R6: Registers 0 to 3 are reserved. They read as 0x00, and writes to them are acknowledged and have no effect.
- R7: Register 18 reads 0x77. Register 19 reads 0x11, which is sub-ID 0001 in bits 7:4 and version 0001 in bits 3:0. Both are read-only, and writes to them are acknowledged and ignored.
- R8: After reset, registers 4 to 17 read 0x00. The select output `sel_code_o[4:0]` is built as {reg4[2], reg4[7:4]}, and the software-select enable `sel_sw_o` equals reg4[3].
- R9: Each stored data byte raises exactly one bit of `wr_stb_o` for one cycle: the bit of the written register. Register contents never change without a strobe. Writes to reserved or read-only registers raise no strobe.
- R10: The data-line drive changes only after a filtered falling edge of the serial clock, or on a start or stop. It is steady while the serial clock is high.
- R11: A pulse on either bus line shorter than FILT local clock cycles is ignored.
- R12: A start condition at any point begins a new transfer from the address byte. A stop returns the slave to idle, and a transfer cut short before its data byte stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| regs_o | output | NREG*8 | Readable view of all registers, register k at bits 8k+7:8k |
| wr_stb_o | output | NREG | One-cycle write strobe per register |
| sel_code_o | output | 5 | Gathered frequency select bits from register 4 |
| sel_sw_o | output | 1 | Software frequency-select enable from register 4 |

## Verification
The hardest state to reach from the ports is the read handoff. A block read must return the count byte before register 0, and the slave must stop driving on the exact bit where the master sends NACK. The stimulus reaches it by running a full block read over all twenty registers, NACKing the last one, and then clocking one extra bit to prove that the line stays released. Glitch rejection needs sub-filter pulses placed inside a live byte, so one byte write carries a short clock pulse in a low phase and a short data pulse in a high phase. The stored value is then compared.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         NREG     = 20,
  parameter int         RSV      = 4,
  parameter int         FILT     = 3,
  parameter logic [7:0] ID_BYTE  = 8'h77,
  parameter logic [7:0] REV_BYTE = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb_o,
  output logic [4:0]        sel_code_o,
  output logic              sel_sw_o
);
  localparam int IW     = $clog2(NREG);
  localparam int CW     = $clog2(FILT + 1);
  localparam int ID_IDX = NREG - 2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_CNT, P_DATA} ph_t;

  logic [1:0]    scl_s, sda_s;
  logic          scl_f, sda_f, scl_q, sda_q;
  logic [CW-1:0] scl_c, sda_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11;
      scl_f <= 1'b1;  sda_f <= 1'b1;
      scl_q <= 1'b1;  sda_q <= 1'b1;
      scl_c <= '0;    sda_c <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (scl_s[1] == scl_f) scl_c <= '0;
      else if (scl_c == CW'(FILT - 1)) begin scl_f <= scl_s[1]; scl_c <= '0; end
      else scl_c <= scl_c + 1'b1;
      if (sda_s[1] == sda_f) sda_c <= '0;
      else if (sda_c == CW'(FILT - 1)) begin sda_f <= sda_s[1]; sda_c <= '0; end
      else sda_c <= sda_c + 1'b1;
    end

  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;
  wire bus_start = scl_f & scl_q & sda_q & ~sda_f;
  wire bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  ph_t        ph;
  logic [3:0] bc;
  logic [6:0] sh, tx;
  logic       ack_q, rw, blk, cnt_first;
  logic [7:0] ptr, left;
  logic [7:0] regs [NREG];

  function automatic logic [7:0] rd_val(input logic [7:0] p);
    if (p < 8'(RSV) || p >= 8'(NREG)) return 8'h00;
    if (p == 8'(ID_IDX))              return ID_BYTE;
    if (p == 8'(ID_IDX + 1))          return REV_BYTE;
    return regs[p[IW-1:0]];
  endfunction

  wire [7:0] rx_byte  = {sh, sda_f};
  wire [7:0] nxt_tx   = cnt_first ? 8'(NREG) : rd_val(ptr);
  wire       writable = (ptr >= 8'(RSV)) && (ptr < 8'(ID_IDX));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_ADDR; bc <= '0; sh <= '0; tx <= '0;
      sda_oe <= 1'b0; ack_q <= 1'b0; rw <= 1'b0; blk <= 1'b0; cnt_first <= 1'b0;
      ptr <= '0; left <= '0; wr_stb_o <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wr_stb_o <= '0;
      if (bus_start) begin
        st <= S_RX; ph <= P_ADDR; bc <= '0; sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX:
            if (scl_rise) begin
              sh <= rx_byte[6:0];
              bc <= bc + 1'b1;
              if (bc == 4'd7) begin
                ack_q <= 1'b1;
                case (ph)
                  P_ADDR:
                    if (rx_byte[7:1] == ADDR7) begin
                      rw <= rx_byte[0];
                      ph <= P_CMD;
                      cnt_first <= rx_byte[0] & blk;
                    end else ack_q <= 1'b0;
                  P_CMD: begin
                    blk  <= (rx_byte == 8'h00);
                    ptr  <= (rx_byte == 8'h00) ? 8'h00 : rx_byte - 8'd1;
                    left <= (rx_byte == 8'h00) ? 8'h00 : 8'h01;
                    ph   <= (rx_byte == 8'h00) ? P_CNT : P_DATA;
                  end
                  P_CNT: begin
                    left <= rx_byte;
                    ph   <= P_DATA;
                  end
                  default:
                    if (left != 8'h00) begin
                      left <= left - 8'd1;
                      ptr  <= ptr + 8'd1;
                      if (writable) begin
                        regs[ptr[IW-1:0]] <= rx_byte;
                        wr_stb_o <= NREG'(1) << ptr;
                      end
                    end else ack_q <= 1'b0;
                endcase
              end
            end else if (scl_fall && bc == 4'd8) begin
              sda_oe <= ack_q;
              st <= ack_q ? S_RACK : S_IDLE;
            end
          S_RACK:
            if (scl_fall) begin
              bc <= '0;
              if (rw) begin
                st <= S_TX;
                tx <= nxt_tx[6:0];
                sda_oe <= ~nxt_tx[7];
                if (!cnt_first) ptr <= ptr + 8'd1;
                cnt_first <= 1'b0;
              end else begin
                st <= S_RX;
                sda_oe <= 1'b0;
              end
            end
          S_TX:
            if (scl_fall) begin
              if (bc == 4'd7) begin
                sda_oe <= 1'b0;
                st <= S_TACK;
              end else begin
                bc <= bc + 1'b1;
                sda_oe <= ~tx[6];
                tx <= {tx[5:0], 1'b0};
              end
            end
          S_TACK:
            if (scl_rise && sda_f) st <= S_IDLE;
            else if (scl_fall) begin
              bc <= '0;
              st <= S_TX;
              tx <= nxt_tx[6:0];
              sda_oe <= ~nxt_tx[7];
              if (!cnt_first) ptr <= ptr + 8'd1;
              cnt_first <= 1'b0;
            end
          default: ;
        endcase
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign regs_o[g*8 +: 8] = rd_val(8'(g));
  end

  assign sel_code_o = {regs[RSV][2], regs[RSV][7:4]};
  assign sel_sw_o   = regs[RSV][3];
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int NREG = 20,
  parameter int RSV  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic [NREG-1:0]   wr_stb_o,
  input logic              scl_fall,
  input logic              bus_start,
  input logic              bus_stop
);
  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));

  // R9
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_o));

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_stb_o) |-> $stable(regs_o));

  // R6
  rsv_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o[RSV-1:0] == '0);

  // R7
  id_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o[NREG-1 -: 2] == 2'b00);

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);
endmodule

bind smb_regslave smb_regslave_chk #(.NREG(NREG), .RSV(RSV)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .regs_o(regs_o),
  .wr_stb_o(wr_stb_o), .scl_fall(scl_fall), .bus_start(bus_start),
  .bus_stop(bus_stop)
);

// File: tb/smb_regslave_tb_top.sv
`timescale 1ns/1ps
module smb_regslave_tb_top;
  localparam int NREG = 20;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  logic [NREG-1:0] wr_stb_o;
  logic [4:0] sel_code_o;
  logic sel_sw_o;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .regs_o(regs_o), .wr_stb_o(wr_stb_o), .sel_code_o(sel_code_o), .sel_sw_o(sel_sw_o)
  );

  int checks = 0, errors = 0, stb_cnt = 0;
  bit cmp_on = 0;
  logic [7:0] m [NREG];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (|wr_stb_o) stb_cnt++;
    if (cmp_on && rst_n) begin
      bit ok = 1;
      int bad = 0;
      for (int i = 0; i < NREG; i++)
        if (regs_o[i*8 +: 8] !== m[i]) begin ok = 0; bad = i; end
      chk(ok, "R9 model register view", regs_o[bad*8 +: 8], m[bad]);
      chk(sel_code_o === {m[4][2], m[4][7:4]} && sel_sw_o === m[4][3] && sda_oe === 1'b0,
          "R8 select outputs at idle", {sel_sw_o, sel_code_o}, {m[4][3], m[4][2], m[4][7:4]});
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_c();
    cmp_on = 0;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(2);
  endtask

  task automatic stop_c();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic settle();
    wq(8);
    cmp_on = 1;
  endtask

  task automatic wr_b(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      if (glitch && i == 4) begin scl_m = 1; wq(2); scl_m = 0; wq(Q); end
      scl_m = 1; wq(Q);
      if (glitch && i == 2) begin sda_m = ~b[i]; wq(2); sda_m = b[i]; wq(Q - 2); end
      else wq(Q);
      scl_m = 0; wq(2);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 0; wq(2);
  endtask

  task automatic rd_b(input bit nack, output logic [7:0] b);
    bit steady = 1;
    logic s0, s1;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1;
      wq(6); s0 = sda_bus;
      wq(7); b[i] = sda_bus;
      wq(6); s1 = sda_bus;
      if (s0 !== b[i] || s1 !== b[i]) steady = 0;
      wq(1); scl_m = 0; wq(2);
    end
    chk(steady, "R10 read bit steady while clock high", steady, 1);
    sda_m = nack; wq(Q); scl_m = 1; wq(2 * Q); scl_m = 0; wq(2); sda_m = 1;
  endtask

  task automatic bwrite(input logic [7:0] cmd, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
    start_c(); wr_b(8'hD2, 0, a0); wr_b(cmd, 0, a1); wr_b(d, 0, a2); stop_c();
  endtask

  task automatic bread(input logic [7:0] cmd, output logic [7:0] v, output bit ok);
    bit a0, a1, a2;
    start_c(); wr_b(8'hD2, 0, a0); wr_b(cmd, 0, a1);
    start_c(); wr_b(8'hD3, 0, a2); rd_b(1, v); stop_c();
    ok = a0 & a1 & a2;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a0, a1, a2, ok;
    logic [7:0] v;
    int s0;
    for (int i = 0; i < NREG; i++) m[i] = 8'h00;
    m[18] = 8'h77; m[19] = 8'h11;
    repeat (5) @(posedge clk);
    rst_n = 1;
    wq(3);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[i*8 +: 8] === m[i], "R8 reset register view", regs_o[i*8 +: 8], m[i]);
    chk(sel_code_o === 5'd0 && sel_sw_o === 1'b0 && sda_oe === 1'b0, "R8 reset outputs", {sel_sw_o, sel_code_o}, 0);
    settle();

    // R1 foreign address
    start_c(); wr_b(8'hA0, 0, a0); wr_b(8'h05, 0, a1); stop_c();
    chk(!a0, "R1 foreign address NACK", a0, 0);
    chk(!a1, "R1 line released after NACK", a1, 0);
    settle();

    // R2 byte write with extra byte
    s0 = stb_cnt;
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'h05, 0, a1); wr_b(8'h5C, 0, a2);
    chk(a0 && a1 && a2, "R2 byte write acks", {a0, a1, a2}, 7);
    wr_b(8'h3C, 0, a0); stop_c();
    chk(!a0, "R2 second data byte NACK", a0, 0);
    m[4] = 8'h5C;
    settle();
    chk(sel_code_o === 5'b10101 && sel_sw_o === 1'b1, "R8 scattered select bits", {sel_sw_o, sel_code_o}, 6'b110101);
    chk(stb_cnt - s0 == 1, "R9 one strobe per write", stb_cnt - s0, 1);

    // R3 byte read
    bread(8'h05, v, ok);
    chk(ok && v == 8'h5C, "R3 byte read offset", v, 8'h5C);

    // R7 identity registers
    bread(8'd19, v, ok);
    chk(ok && v == 8'h77, "R7 id register", v, 8'h77);
    bread(8'd20, v, ok);
    chk(ok && v == 8'h11, "R7 sub-id and version", v, 8'h11);
    s0 = stb_cnt;
    bwrite(8'd19, 8'h00, a0, a1, a2);
    chk(a0 && a1 && a2, "R7 write to id acked", {a0, a1, a2}, 7);
    bread(8'd19, v, ok);
    chk(v == 8'h77, "R7 id unchanged after write", v, 8'h77);
    chk(stb_cnt == s0, "R7 no strobe for id write", stb_cnt - s0, 0);

    // R6 reserved registers
    s0 = stb_cnt;
    bwrite(8'd1, 8'hFF, a0, a1, a2);
    chk(a0 && a1 && a2, "R6 reserved write acked", {a0, a1, a2}, 7);
    bread(8'd1, v, ok);
    chk(v == 8'h00, "R6 reserved reads zero", v, 0);
    chk(stb_cnt == s0, "R6 no strobe for reserved write", stb_cnt - s0, 0);

    // R4 block write of 8 bytes then one extra
    s0 = stb_cnt;
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'h00, 0, a1); wr_b(8'd8, 0, a2);
    chk(a0 && a1 && a2, "R4 block header acks", {a0, a1, a2}, 7);
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      wr_b(8'h10 + 8'(i), 0, a0);
      ok &= a0;
    end
    chk(ok, "R4 block data acks", ok, 1);
    wr_b(8'h99, 0, a0); stop_c();
    chk(!a0, "R4 byte past count NACK", a0, 0);
    for (int i = 4; i < 8; i++) m[i] = 8'h10 + 8'(i);
    settle();
    chk(stb_cnt - s0 == 4, "R9 strobes only for writable", stb_cnt - s0, 4);

    // R5 block read
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'h00, 0, a1);
    start_c(); wr_b(8'hD3, 0, a2);
    chk(a0 && a1 && a2, "R5 block read header acks", {a0, a1, a2}, 7);
    rd_b(0, v);
    chk(v == 8'(NREG), "R5 count byte first", v, NREG);
    for (int i = 0; i < NREG; i++) begin
      rd_b(i == NREG - 1, v);
      chk(v == m[i], $sformatf("R5 block read register %0d", i), v, m[i]);
    end
    wq(Q); scl_m = 1; wq(Q);
    chk(sda_bus === 1'b1, "R5 released after NACK", sda_bus, 1);
    wq(Q); scl_m = 0; wq(2);
    stop_c(); settle();

    // R11 glitches inside a byte write
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'd8, 0, a1); wr_b(8'h6B, 1, a2); stop_c();
    chk(a0 && a1 && a2, "R11 glitched write acks", {a0, a1, a2}, 7);
    m[7] = 8'h6B;
    settle();
    bread(8'd8, v, ok);
    chk(v == 8'h6B, "R11 glitched value stored", v, 8'h6B);

    // R12 stop before data, restart mid transfer
    s0 = stb_cnt;
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'd7, 0, a1); stop_c();
    settle();
    chk(stb_cnt == s0, "R12 cut transfer stores nothing", stb_cnt - s0, 0);
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'd6, 0, a1);
    start_c(); wr_b(8'hD2, 0, a0); wr_b(8'd6, 0, a1); wr_b(8'h42, 0, a2); stop_c();
    chk(a0 && a1 && a2, "R12 restart transfer acks", {a0, a1, a2}, 7);
    m[5] = 8'h42;
    settle();
    bread(8'd6, v, ok);
    chk(v == 8'h42, "R12 restart write stored", v, 8'h42);

    wq(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule